// File: doc/BRIEF.md
# Eight-Line Interrupt Priority Resolver

This block takes a set of interrupt request lines and decides which one the processor services next. Each line sets a bit in a request register. A mask register removes individual lines from consideration. An in-service register records which requests the processor has accepted but not yet finished. The resolver picks the best pending unmasked request. It raises `int_o` only when that request outranks every level that is already in service, so a handler can be interrupted by a more urgent source but never by an equal or less urgent one.

The processor answers with a one-cycle acknowledge strobe. On that strobe the winning line moves from the request register to the in-service register, and its index appears on `grant_level_o`. A handler ends with an end-of-interrupt command, which is either specific (it names a level) or nonspecific (it clears the most urgent in-service level). In automatic end-of-interrupt mode no in-service bit is kept at all. Priority is either fixed, with line 0 first, or rotating, where a serviced line drops to the bottom of the order once it finishes. Requests are latched on rising edges or sampled as levels.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Edge mode (`cfg_level_i`=0): a rising edge on `irq_i[n]` latches request n. A line that stays high produces only one request; a new request needs a fall and a new rise.
- R2: Level mode (`cfg_level_i`=1): the request register follows the lines with one cycle of delay. A line that drops before acknowledge withdraws its request. A line that stays high requests again after its service ends.
- R3: Mask bit n = 1 (written through `mask_we_i`/`mask_wdata_i`, reset value 0) keeps line n from raising `int_o` or winning. A latched request survives masking and is granted once the bit is cleared.
- R4: In fixed mode (`cfg_rotate_i`=0) a lower line index always wins over a higher one.
- R5: `int_o` is high only when the winning request has strictly higher priority than every in-service level. A more urgent line preempts a handler; an equal or less urgent one waits.
- R6: An `ack_i` pulse while `int_o` is high clears the winner's request bit and, outside automatic mode, sets its in-service bit. An acknowledged edge request never raises `int_o` again.
- R7: A specific end-of-interrupt (`eoi_valid_i`=1, `eoi_specific_i`=1) clears the in-service bit named by `eoi_level_i`.
- R8: A nonspecific end-of-interrupt (`eoi_valid_i`=1, `eoi_specific_i`=0) clears the highest-priority in-service bit under the current order.
- R9: In rotating mode (`cfg_rotate_i`=1), ending service of line L makes line L+1 (mod 8) the most urgent and L the least. Priority starts at line 0 after reset.
- R10: In automatic mode (`cfg_auto_eoi_i`=1) an acknowledge sets no in-service bit, so any pending request, including a less urgent one, raises `int_o` immediately. In rotating mode the acknowledged line becomes least urgent.
- R11: `grant_level_o` shows the index of the most recently acknowledged line from the cycle after the acknowledge. It is 0 after reset.
- R12: After reset `int_o` is low and the request, mask and in-service registers are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | 8 | Interrupt request lines |
| cfg_rotate_i | input | 1 | 1 = rotating priority, 0 = fixed |
| cfg_level_i | input | 1 | 1 = level sensing, 0 = rising edge |
| cfg_auto_eoi_i | input | 1 | 1 = automatic end of interrupt |
| mask_we_i | input | 1 | Mask register write enable |
| mask_wdata_i | input | 8 | New mask value, bit n masks line n |
| eoi_valid_i | input | 1 | End-of-interrupt command strobe |
| eoi_specific_i | input | 1 | 1 = specific, 0 = nonspecific |
| eoi_level_i | input | 3 | Level cleared by a specific command |
| ack_i | input | 1 | One-cycle acknowledge strobe |
| int_o | output | 1 | Interrupt request to the processor |
| grant_level_o | output | 3 | Index of the last acknowledged line |

## Verification
The assertions assume that the three configuration inputs stay constant between resets, that `ack_i` pulses for one cycle only while `int_o` is high, and that an end-of-interrupt command never arrives in the same cycle as an acknowledge. The directed stimulus follows these rules. It changes configuration only while reset is held, issues an acknowledge only after it has observed `int_o` high, and spaces commands at least one cycle apart. Request lines change on the falling clock edge, so every latched edge lines up with a known rising edge.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_prio_pkg::*;
#(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_i,
  input  trig_mode_e         trig_i,
  input  logic [N_LINES-1:0] clr_i,
  output logic [N_LINES-1:0] irr_o
);
  logic [N_LINES-1:0] irq_d_q, irr_q, rise_w, set_w, keep_w, irr_d;

  assign rise_w = irq_i & ~irq_d_q;
  assign set_w  = (trig_i == TRIG_LEVEL) ? irq_i : rise_w;
  assign keep_w = (trig_i == TRIG_LEVEL) ? '0 : irr_q;
  assign irr_d  = (keep_w | set_w) & ~clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_d_q <= '0;
      irr_q   <= '0;
    end else begin
      irq_d_q <= irq_i;
      irr_q   <= irr_d;
    end
  end

  assign irr_o = irr_q;

  for (genvar k = 0; k < N_LINES; k++) begin : g_chk
    AST_EDGE_HELD_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i == TRIG_EDGE && !irr_q[k] && irq_d_q[k]) |=> !irr_q[k]); // R1
    AST_ACK_CLEARS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i[k] |=> !irr_q[k]); // R6
  end
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver #(
  parameter int N_LINES = 8,
  localparam int LW = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irr_i,
  input  logic [N_LINES-1:0] mask_i,
  input  logic [N_LINES-1:0] isr_i,
  input  logic [LW-1:0]      base_i,
  output logic               int_req_o,
  output logic [LW-1:0]      win_line_o,
  output logic               svc_valid_o,
  output logic [LW-1:0]      svc_line_o
);
  // Scan from the most urgent position (base) downward; returns {found, line}.
  function automatic logic [LW:0] pick_first(input logic [N_LINES-1:0] vec,
                                             input logic [LW-1:0] base);
    logic [LW:0]   res;
    logic [LW-1:0] idx;
    res = '0;
    for (int k = N_LINES - 1; k >= 0; k--) begin
      idx = base + LW'(k);
      if (vec[idx]) res = {1'b1, idx};
    end
    return res;
  endfunction

  // Distance from the most urgent position; smaller is more urgent.
  function automatic logic [LW-1:0] rank_of(input logic [LW-1:0] line,
                                            input logic [LW-1:0] base);
    return line - base;
  endfunction

  logic [N_LINES-1:0] pend_w;
  logic [LW:0]        win_w, svc_w;
  logic               outranks_w;

  assign pend_w      = irr_i & ~mask_i;
  assign win_w       = pick_first(pend_w, base_i);
  assign svc_w       = pick_first(isr_i, base_i);
  assign win_line_o  = win_w[LW-1:0];
  assign svc_valid_o = svc_w[LW];
  assign svc_line_o  = svc_w[LW-1:0];
  assign outranks_w  = !svc_w[LW] ||
                       (rank_of(win_w[LW-1:0], base_i) < rank_of(svc_w[LW-1:0], base_i));
  assign int_req_o   = win_w[LW] && outranks_w;

  AST_WIN_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    int_req_o |-> (irr_i[win_line_o] && !mask_i[win_line_o])); // R3
  AST_WIN_NOT_SERVICED: assert property (@(posedge clk) disable iff (!rst_n)
    int_req_o |-> !isr_i[win_line_o]); // R5
  AST_SVC_IS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid_o |-> isr_i[svc_line_o]); // R8
endmodule

// File: rtl/irq_svc_ctrl.sv
module irq_svc_ctrl #(
  parameter int N_LINES = 8,
  localparam int LW = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rotate_i,
  input  logic               auto_eoi_i,
  input  logic               ack_i,
  input  logic               int_req_i,
  input  logic [LW-1:0]      win_line_i,
  input  logic               eoi_valid_i,
  input  logic               eoi_specific_i,
  input  logic [LW-1:0]      eoi_level_i,
  input  logic               svc_valid_i,
  input  logic [LW-1:0]      svc_line_i,
  output logic [N_LINES-1:0] isr_o,
  output logic [LW-1:0]      base_o,
  output logic [LW-1:0]      grant_o,
  output logic [N_LINES-1:0] ack_clr_o
);
  logic [N_LINES-1:0] isr_q, isr_set_w, eoi_clr_w;
  logic [LW-1:0]      rot_q, grant_q, eoi_line_w;
  logic               ack_fire_w, eoi_hit_w;

  assign ack_fire_w = ack_i && int_req_i;
  assign ack_clr_o  = ack_fire_w ? (N_LINES'(1) << win_line_i) : '0;
  assign isr_set_w  = auto_eoi_i ? '0 : ack_clr_o;

  assign eoi_line_w = eoi_specific_i ? eoi_level_i : svc_line_i;
  assign eoi_hit_w  = eoi_valid_i && (eoi_specific_i ? isr_q[eoi_level_i] : svc_valid_i);
  assign eoi_clr_w  = eoi_hit_w ? (N_LINES'(1) << eoi_line_w) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q   <= '0;
      rot_q   <= '0;
      grant_q <= '0;
    end else begin
      isr_q <= (isr_q & ~eoi_clr_w) | isr_set_w;
      if (ack_fire_w) grant_q <= win_line_i;
      if (rotate_i) begin
        if (eoi_hit_w)                     rot_q <= eoi_line_w + LW'(1);
        else if (ack_fire_w && auto_eoi_i) rot_q <= win_line_i + LW'(1);
      end
    end
  end

  assign isr_o   = isr_q;
  assign base_o  = rotate_i ? rot_q : '0;
  assign grant_o = grant_q;

  AST_ACK_ENTERS_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire_w && !auto_eoi_i) |=> isr_q[$past(win_line_i)]); // R6
  AST_AUTO_NO_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire_w && auto_eoi_i && !eoi_valid_i) |=> (isr_q == $past(isr_q))); // R10
  AST_SPEC_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid_i && eoi_specific_i && !(ack_fire_w && win_line_i == eoi_level_i))
      |=> !isr_q[$past(eoi_level_i)]); // R7
  AST_GRANT_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire_w |=> (grant_o == $past(win_line_i))); // R11
  AST_ROTATE_AFTER_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    (rotate_i && eoi_valid_i && eoi_specific_i && isr_q[eoi_level_i])
      |=> (!rotate_i || base_o == LW'($past(eoi_level_i) + LW'(1)))); // R9
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int N_LINES = 8,
  localparam int LW = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_i,
  input  logic               cfg_rotate_i,
  input  logic               cfg_level_i,
  input  logic               cfg_auto_eoi_i,
  input  logic               mask_we_i,
  input  logic [N_LINES-1:0] mask_wdata_i,
  input  logic               eoi_valid_i,
  input  logic               eoi_specific_i,
  input  logic [LW-1:0]      eoi_level_i,
  input  logic               ack_i,
  output logic               int_o,
  output logic [LW-1:0]      grant_level_o
);
  logic [N_LINES-1:0] mask_q, irr_w, isr_w, ack_clr_w;
  logic [LW-1:0]      base_w, win_line_w, svc_line_w;
  logic               int_req_w, svc_valid_w;
  trig_mode_e         trig_w;

  assign trig_w = cfg_level_i ? TRIG_LEVEL : TRIG_EDGE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_wdata_i;
  end

  irq_req_latch #(.N_LINES(N_LINES)) u_req (
    .clk   (clk),
    .rst_n (rst_n),
    .irq_i (irq_i),
    .trig_i(trig_w),
    .clr_i (ack_clr_w),
    .irr_o (irr_w)
  );

  irq_resolver #(.N_LINES(N_LINES)) u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .irr_i      (irr_w),
    .mask_i     (mask_q),
    .isr_i      (isr_w),
    .base_i     (base_w),
    .int_req_o  (int_req_w),
    .win_line_o (win_line_w),
    .svc_valid_o(svc_valid_w),
    .svc_line_o (svc_line_w)
  );

  irq_svc_ctrl #(.N_LINES(N_LINES)) u_svc (
    .clk           (clk),
    .rst_n         (rst_n),
    .rotate_i      (cfg_rotate_i),
    .auto_eoi_i    (cfg_auto_eoi_i),
    .ack_i         (ack_i),
    .int_req_i     (int_req_w),
    .win_line_i    (win_line_w),
    .eoi_valid_i   (eoi_valid_i),
    .eoi_specific_i(eoi_specific_i),
    .eoi_level_i   (eoi_level_i),
    .svc_valid_i   (svc_valid_w),
    .svc_line_i    (svc_line_w),
    .isr_o         (isr_w),
    .base_o        (base_w),
    .grant_o       (grant_level_o),
    .ack_clr_o     (ack_clr_w)
  );

  assign int_o = int_req_w;

  AST_MASK_BLOCKS_INT: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> !mask_q[win_line_w]); // R3
  AST_FIXED_LOW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (int_o && !cfg_rotate_i) |-> ((irr_w & ~mask_q & ((N_LINES'(1) << win_line_w) - N_LINES'(1))) == '0)); // R4
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       cfg_rotate = 1'b0, cfg_level = 1'b0, cfg_auto = 1'b0;
  logic       mask_we = 1'b0;
  logic [7:0] mask_wdata = '0;
  logic       eoi_valid = 1'b0, eoi_specific = 1'b0;
  logic [2:0] eoi_level = '0;
  logic       ack = 1'b0;
  logic       int_o;
  logic [2:0] grant;
  int         n_checks = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_i(irq),
    .cfg_rotate_i(cfg_rotate), .cfg_level_i(cfg_level), .cfg_auto_eoi_i(cfg_auto),
    .mask_we_i(mask_we), .mask_wdata_i(mask_wdata),
    .eoi_valid_i(eoi_valid), .eoi_specific_i(eoi_specific), .eoi_level_i(eoi_level),
    .ack_i(ack), .int_o(int_o), .grant_level_o(grant)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic restart(input logic rot, input logic lvl, input logic au);
    @(negedge clk);
    rst_n = 1'b0; irq = '0; ack = 1'b0; eoi_valid = 1'b0; mask_we = 1'b0;
    cfg_rotate = rot; cfg_level = lvl; cfg_auto = au;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic pulse(input logic [7:0] lines);
    irq = lines; tick(); irq = '0; tick();
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic eoi_spec(input logic [2:0] lvl);
    eoi_valid = 1'b1; eoi_specific = 1'b1; eoi_level = lvl; tick(); eoi_valid = 1'b0;
  endtask

  task automatic eoi_ns();
    eoi_valid = 1'b1; eoi_specific = 1'b0; tick(); eoi_valid = 1'b0;
  endtask

  task automatic write_mask(input logic [7:0] m);
    mask_we = 1'b1; mask_wdata = m; tick(); mask_we = 1'b0;
  endtask

  task automatic t_reset();
    restart(1'b0, 1'b0, 1'b0);
    check("R12 int after reset", int_o, 0);
    check("R11 grant after reset", grant, 0);
  endtask

  task automatic t_fixed();
    restart(1'b0, 1'b0, 1'b0);
    pulse(8'b0010_0100);
    check("R4 int with lines 2,5", int_o, 1);
    do_ack();
    check("R4 winner is line 2", grant, 2);
    check("R5 line 5 waits behind 2", int_o, 0);
    eoi_spec(3'd2);
    check("R7 specific clear of 2 frees 5", int_o, 1);
    do_ack();
    check("R11 grant line 5", grant, 5);
    eoi_ns();
    check("R6 no re-raise after service", int_o, 0);
  endtask

  task automatic t_nesting();
    restart(1'b0, 1'b0, 1'b0);
    pulse(8'h10); do_ack();
    check("R11 grant line 4", grant, 4);
    pulse(8'h40);
    check("R5 line 6 blocked by 4", int_o, 0);
    pulse(8'h02);
    check("R5 line 1 preempts 4", int_o, 1);
    do_ack();
    check("R5 grant line 1", grant, 1);
    pulse(8'h08);
    check("R5 line 3 blocked by 1", int_o, 0);
    eoi_ns();
    check("R8 nonspecific clears 1 first", int_o, 1);
    do_ack();
    check("R8 grant line 3", grant, 3);
    eoi_ns();
    check("R8 line 4 still blocks 6", int_o, 0);
    eoi_ns();
    check("R8 line 6 freed", int_o, 1);
    do_ack();
    check("R8 grant line 6", grant, 6);
  endtask

  task automatic t_mask();
    restart(1'b0, 1'b0, 1'b0);
    write_mask(8'h01);
    pulse(8'h01);
    check("R3 masked line 0 silent", int_o, 0);
    pulse(8'h80);
    check("R3 line 7 raises int", int_o, 1);
    do_ack();
    check("R3 line 7 wins over masked 0", grant, 7);
    eoi_spec(3'd7);
    check("R3 still silent while masked", int_o, 0);
    write_mask(8'h00);
    check("R3 unmask releases line 0", int_o, 1);
    do_ack();
    check("R3 grant line 0", grant, 0);
  endtask

  task automatic t_rotate();
    restart(1'b1, 1'b0, 1'b0);
    pulse(8'h08); do_ack();
    check("R9 grant line 3", grant, 3);
    eoi_spec(3'd3);
    pulse(8'b0010_0010);
    do_ack();
    check("R9 line 5 beats 1 after rotation", grant, 5);
    eoi_ns();
    check("R9 line 1 pending", int_o, 1);
    do_ack();
    check("R9 grant line 1", grant, 1);
  endtask

  task automatic t_auto();
    restart(1'b0, 1'b0, 1'b1);
    pulse(8'h20); do_ack();
    check("R10 grant line 5", grant, 5);
    pulse(8'h40);
    check("R10 lower line raises without EOI", int_o, 1);
    do_ack();
    check("R10 grant line 6", grant, 6);
  endtask

  task automatic t_auto_rotate();
    restart(1'b1, 1'b0, 1'b1);
    pulse(8'h01); do_ack();
    check("R10 grant line 0", grant, 0);
    pulse(8'h05);
    do_ack();
    check("R10 line 2 beats rotated-down 0", grant, 2);
  endtask

  task automatic t_level();
    restart(1'b0, 1'b1, 1'b0);
    irq = 8'h10; tick();
    check("R2 level raises int", int_o, 1);
    irq = 8'h00; tick();
    check("R2 drop withdraws request", int_o, 0);
    irq = 8'h10; tick();
    do_ack();
    check("R2 grant line 4", grant, 4);
    check("R2 held line waits while in service", int_o, 0);
    eoi_spec(3'd4);
    check("R2 held line requests again", int_o, 1);
    irq = 8'h00; tick();
    check("R2 drop withdraws again", int_o, 0);
  endtask

  task automatic t_edge_hold();
    restart(1'b0, 1'b0, 1'b0);
    irq = 8'h04; tick();
    check("R1 edge raises int", int_o, 1);
    do_ack();
    check("R1 grant line 2", grant, 2);
    eoi_spec(3'd2);
    check("R1 held line gives one request", int_o, 0);
    irq = 8'h00; tick();
    irq = 8'h04; tick();
    check("R1 new rise requests again", int_o, 1);
    irq = 8'h00;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fixed();
    t_nesting();
    t_mask();
    t_rotate();
    t_auto();
    t_auto_rotate();
    t_level();
    t_edge_hold();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule